// File: doc/BRIEF.md
# Pixel to Bus Cycle Packer

This block turns a stream of pixels into the data cycles of a narrow parallel display bus. Each pixel is 12, 16, 18 or 24 bits deep and the bus has 8, 9, 12 or 16 data lines. The block picks how many bus cycles each pixel needs from that pair. It either spends one, two or three cycles on each pixel, or it packs two pixels into three cycles. Every word leaves on a valid/ready stream with the address/command line at its data level, ready for a downstream strobe timer.

A transfer begins with a one-cycle `start` pulse. At that pulse the block captures the depth and line selections and the pixel count (width times height of the region). While the transfer runs, `busy` is high. The block accepts exactly that many pixels, and `frame_done` pulses once the bus word holding the final bits has been taken. Pixels arrive right-aligned on `s_pixel`; bits above the selected depth are ignored. Bus words leave right-aligned on `m_data`.

Back-pressure works as follows. An input pixel is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` stays low while any word of the current pixel, or pixel pair, is still waiting. An output word is taken when `m_valid` and `m_ready` are both high. Until then, `m_valid` and `m_data` hold steady whatever `m_ready` does. PIX_W must be at least 24 and BUS_W at least 16.

Top module: `pix_bus_packer`

## Requirements
- R1: Depth select 0/1/2/3 means 12/16/18/24 bits, and line select 0/1/2/3 means 8/9/12/16 lines. The accepted pairs are those where depth/lines is 1, 2 or 3, plus those where 2*depth/lines is 3. A start pulse with any other pair sets `cfg_err`, which stays high until reset, and `busy` stays low.
- R2: When depth equals lines, each pixel gives one word equal to its low `lines` bits.
- R3: When depth is 2 or 3 times lines, each pixel gives that many words, most significant slice first. Word k carries pixel bits [depth-1-k*lines -: lines]. For 16 bits on 8 lines this means upper byte then lower byte. For 24 bits on 8 lines it means [23:16], [15:8], [7:0].
- R4: When 2*depth is 3 times lines, pixels A and B give three words. The first is A's top `lines` bits. The second holds A's low lines/2 bits in its upper half and B's top lines/2 bits in its lower half. The third is B's low `lines` bits.
- R5: In that paired format, an odd final pixel gives two words: its top `lines` bits, then its low lines/2 bits in the upper half with zeros below.
- R6: `s_ready` is low whenever an output word is pending, and high only while busy with pixels still owed and no word pending.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` does not change on the next cycle.
- R8: Exactly the captured count of pixels is accepted in a transfer, and `s_ready` is low once the count is reached and whenever the block is idle.
- R9: `frame_done` is high for exactly one cycle, the cycle after the handshake of the transfer's last word. In that same cycle `busy` goes low.
- R10: A start pulse is ignored while busy or when the count is zero. Depth, lines and count are taken only at an accepted start, so changes to them during a transfer have no effect.
- R11: Bits of `m_data` above the selected line count are zero, and `m_a0` is high (data level) with every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 2 | Pixel depth select |
| cfg_lines | input | 2 | Bus line count select |
| cfg_pix_count | input | CNT_W | Pixels in the transfer |
| start | input | 1 | One-cycle transfer start request |
| busy | output | 1 | Transfer in progress |
| cfg_err | output | 1 | Sticky unsupported-pair flag |
| frame_done | output | 1 | One-cycle end-of-transfer pulse |
| s_valid | input | 1 | Pixel valid |
| s_ready | output | 1 | Pixel ready |
| s_pixel | input | PIX_W | Pixel, right-aligned |
| m_valid | output | 1 | Bus word valid |
| m_ready | input | 1 | Bus word ready |
| m_data | output | BUS_W | Bus word, right-aligned |
| m_a0 | output | 1 | Address/command line level, data = 1 |

## Verification
Directed frames cover 16 bits on 8 lines and 24 bits on 8 lines, where a swapped byte order would show at once. Random frames then cover all nine accepted pairs, with random pixels, random gaps in `s_valid` and random `m_ready` stalls. Odd and even counts in the paired format tell a correct half-word split and lone-pixel tail from a shifted or mis-merged one. After the count is reached, extra pixels stay offered to catch over-acceptance. Further cases cover a rejected pair, a zero count, and a start pulse plus changed configuration in the middle of a transfer, which show whether configuration is captured only at start.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

  typedef enum logic [1:0] {
    FMT_1X = 2'd0,
    FMT_2X = 2'd1,
    FMT_3X = 2'd2,
    FMT_3H = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       ok;
    fmt_e       fmt;
    logic [4:0] depth_n;
    logic [4:0] lines_n;
    logic [1:0] ncyc;
  } mode_t;

  function automatic mode_t decode_mode(input logic [1:0] dsel, input logic [1:0] lsel);
    mode_t m;
    int d;
    int l;
    int q;
    case (dsel)
      2'd0: d = 12;
      2'd1: d = 16;
      2'd2: d = 18;
      default: d = 24;
    endcase
    case (lsel)
      2'd0: l = 8;
      2'd1: l = 9;
      2'd2: l = 12;
      default: l = 16;
    endcase
    m.depth_n = 5'(d);
    m.lines_n = 5'(l);
    m.ok      = 1'b0;
    m.fmt     = FMT_1X;
    m.ncyc    = 2'd1;
    if ((d % l) == 0) begin
      q = d / l;
      if (q >= 1 && q <= 3) begin
        m.ok   = 1'b1;
        m.fmt  = fmt_e'(2'(q - 1));
        m.ncyc = 2'(q);
      end
    end else if (((2 * d) % l) == 0 && ((2 * d) / l) == 3) begin
      m.ok   = 1'b1;
      m.fmt  = FMT_3H;
      m.ncyc = 2'd3;
    end
    return m;
  endfunction

endpackage

// File: rtl/pbp_mode_dec.sv
module pbp_mode_dec
  import pbp_pkg::*;
(
  input  logic [1:0] dsel,
  input  logic [1:0] lsel,
  output mode_t      mode
);
  assign mode = decode_mode(dsel, lsel);
endmodule

// File: rtl/pbp_frame_ctl.sv
module pbp_frame_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             mode_ok,
  input  logic             pix_fire,
  input  logic             word_fire,
  input  logic             final_word,
  output logic             busy,
  output logic             cfg_err,
  output logic             frame_done,
  output logic             capture,
  output logic             last_pix,
  output logic             owed
);
  logic [CNT_W-1:0] remaining;

  assign capture  = start && !busy && mode_ok && (count != '0);
  assign last_pix = (remaining == CNT_W'(1));
  assign owed     = busy && (remaining != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cfg_err    <= 1'b0;
      frame_done <= 1'b0;
      remaining  <= '0;
    end else begin
      frame_done <= 1'b0;
      if (start && !busy && !mode_ok) cfg_err <= 1'b1;
      if (capture) begin
        busy      <= 1'b1;
        remaining <= count;
      end else if (busy) begin
        if (pix_fire) remaining <= remaining - CNT_W'(1);
        if (word_fire && final_word && remaining == '0) begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pbp_shifter.sv
module pbp_shifter
  import pbp_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode,
  input  logic             pix_fire,
  input  logic [PIX_W-1:0] pix,
  input  logic             last_pix,
  input  logic             word_fire,
  output logic [BUS_W-1:0] word,
  output logic             pending,
  output logic             final_word
);
  localparam int SH_W = 2 * PIX_W;

  logic [SH_W-1:0] sreg;
  logic [SH_W-1:0] aligned;
  logic [1:0]      left;
  logic            half;

  assign aligned    = {pix, {PIX_W{1'b0}}} << (PIX_W - int'(mode.depth_n));
  assign pending    = (left != 2'd0);
  assign final_word = (left == 2'd1);
  assign word       = sreg[SH_W-1 -: BUS_W] >> (BUS_W - int'(mode.lines_n));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= 2'd0;
      half <= 1'b0;
    end else if (pix_fire) begin
      if (mode.fmt == FMT_3H && half) begin
        sreg <= sreg | (aligned >> mode.depth_n);
        left <= 2'd3;
        half <= 1'b0;
      end else if (mode.fmt == FMT_3H) begin
        sreg <= aligned;
        if (last_pix) left <= 2'd2;
        else          half <= 1'b1;
      end else begin
        sreg <= aligned;
        left <= mode.ncyc;
      end
    end else if (word_fire) begin
      sreg <= sreg << mode.lines_n;
      left <= left - 2'd1;
    end
  end
endmodule

// File: rtl/pix_bus_packer.sv
module pix_bus_packer
  import pbp_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_depth,
  input  logic [1:0]       cfg_lines,
  input  logic [CNT_W-1:0] cfg_pix_count,
  input  logic             start,
  output logic             busy,
  output logic             cfg_err,
  output logic             frame_done,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_pixel,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [BUS_W-1:0] m_data,
  output logic             m_a0
);
  mode_t dec_mode;
  mode_t mode_q;
  logic  capture, last_pix, owed, pending, final_word;
  logic  pix_fire, word_fire;

  pbp_mode_dec u_dec (
    .dsel (cfg_depth),
    .lsel (cfg_lines),
    .mode (dec_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (capture) mode_q <= dec_mode;
  end

  assign s_ready   = owed && !pending;
  assign m_valid   = pending;
  assign m_a0      = 1'b1;
  assign pix_fire  = s_valid && s_ready;
  assign word_fire = m_valid && m_ready;

  pbp_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .count      (cfg_pix_count),
    .mode_ok    (dec_mode.ok),
    .pix_fire   (pix_fire),
    .word_fire  (word_fire),
    .final_word (final_word),
    .busy       (busy),
    .cfg_err    (cfg_err),
    .frame_done (frame_done),
    .capture    (capture),
    .last_pix   (last_pix),
    .owed       (owed)
  );

  pbp_shifter #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_shf (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .pix_fire   (pix_fire),
    .pix        (s_pixel),
    .last_pix   (last_pix),
    .word_fire  (word_fire),
    .word       (m_data),
    .pending    (pending),
    .final_word (final_word)
  );
endmodule

// File: rtl/pbp_checker.sv
module pbp_checker #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cfg_err,
  input logic             frame_done,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [BUS_W-1:0] m_data
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!s_ready && !m_valid));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);

  assert_sticky_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind pix_bus_packer pbp_checker #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .cfg_err    (cfg_err),
  .frame_done (frame_done),
  .s_ready    (s_ready),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data)
);

// File: tb/sim_pix_bus_packer.sv
module sim_pix_bus_packer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_depth = 2'd0, cfg_lines = 2'd0;
  logic [15:0] cfg_pix_count = 16'd0;
  logic        start = 1'b0;
  logic        busy, cfg_err, frame_done;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_pixel = 24'd0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [15:0] m_data;
  logic        m_a0;

  pix_bus_packer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_lines(cfg_lines),
    .cfg_pix_count(cfg_pix_count), .start(start), .busy(busy), .cfg_err(cfg_err),
    .frame_done(frame_done), .s_valid(s_valid), .s_ready(s_ready), .s_pixel(s_pixel),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_a0(m_a0)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errs = 0;
  int checks = 0;

  logic [23:0] pixq[$];
  int          expq[$];
  string       tagq[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dbits(input int s);
    case (s) 0: return 12; 1: return 16; 2: return 18; default: return 24; endcase
  endfunction

  function automatic int lbits(input int s);
    case (s) 0: return 8; 1: return 9; 2: return 12; default: return 16; endcase
  endfunction

  // R1: 0..2 = one/two/three cycles per pixel, 3 = two pixels in three cycles, -1 = rejected
  function automatic int fmt_of(input int ds, input int ls);
    int d = dbits(ds);
    int l = lbits(ls);
    if (d % l == 0 && d / l >= 1 && d / l <= 3) return d / l - 1;
    if ((2 * d) % l == 0 && (2 * d) / l == 3) return 3;
    return -1;
  endfunction

  function automatic void build(input int ds, input int ls);
    int d = dbits(ds);
    int l = lbits(ls);
    int f = fmt_of(ds, ls);
    int lm = (1 << l) - 1;
    int hm = (1 << (l / 2)) - 1;
    int i = 0;
    expq.delete();
    tagq.delete();
    while (i < pixq.size()) begin
      int a = int'(pixq[i]) & ((1 << d) - 1);
      if (f < 3) begin
        for (int k = 0; k <= f; k++) begin
          expq.push_back((a >> (d - (k + 1) * l)) & lm);
          tagq.push_back(f == 0 ? "R2" : "R3");
        end
        i++;
      end else if (i + 1 < pixq.size()) begin
        int b = int'(pixq[i+1]) & ((1 << d) - 1);
        expq.push_back(a >> (d - l));
        expq.push_back(((a & hm) << (l / 2)) | (b >> (d - l / 2)));
        expq.push_back(b & lm);
        for (int k = 0; k < 3; k++) tagq.push_back("R4");
        i += 2;
      end else begin
        expq.push_back(a >> (d - l));
        expq.push_back((a & hm) << (l / 2));
        tagq.push_back("R5");
        tagq.push_back("R5");
        i++;
      end
    end
  endfunction

  task automatic run_frame(input int ds, input int ls, input bit inject);
    int n = pixq.size();
    int pidx = 0;
    int widx = 0;
    bit done = 0;
    int l = lbits(ls);
    build(ds, ls);
    @(negedge clk);
    cfg_depth = 2'(ds);
    cfg_lines = 2'(ls);
    cfg_pix_count = 16'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc > 0) @(negedge clk);
      m_ready = ($urandom % 4) != 0;
      if (pidx < n) begin
        s_valid = ($urandom % 4) != 0;
        s_pixel = pixq[pidx];
      end else begin
        s_valid = 1'b1;
        s_pixel = 24'hFFFFFF;
      end
      // R10: start and new settings while busy must not disturb this transfer
      if (inject && cyc == 2) begin
        start = 1'b1;
        cfg_pix_count = 16'd7;
        cfg_depth = ~cfg_depth;
      end else start = 1'b0;
      #1;
      if (frame_done) begin
        done = 1;
        break;
      end
      if (s_valid && s_ready) begin
        if (pidx >= n) chk(0, "R8 extra pixel accepted", pidx, n);
        pidx++;
      end
      if (m_valid && m_ready) begin
        if (widx < expq.size())
          chk(int'(m_data) == expq[widx], inject ? {tagq[widx], " R10"} : tagq[widx], m_data, expq[widx]);
        else
          chk(0, "R9 word after last", widx, expq.size());
        chk((int'(m_data) >> l) == 0 && m_a0 == 1'b1, "R11", {m_a0, m_data}, 0);
        widx++;
      end
    end
    s_valid = 1'b0;
    m_ready = 1'b0;
    start = 1'b0;
    chk(done, "R9 frame_done seen", done, 1);
    chk(busy == 1'b0, "R9 busy cleared", busy, 0);
    chk(widx == expq.size(), "R9 word count", widx, expq.size());
    chk(pidx == n, "R8 pixel count", pidx, n);
    @(negedge clk);
    chk(frame_done == 1'b0, "R9 one cycle pulse", frame_done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && s_ready == 0 && m_valid == 0 && frame_done == 0 && cfg_err == 0,
        "R8 reset state", {busy, s_ready, m_valid, frame_done, cfg_err}, 0);

    // R3 directed: 16 bits on 8 lines, upper byte first
    pixq = '{24'h00ABCD, 24'h001234};
    run_frame(1, 0, 0);
    // R3 directed: 24 bits on 8 lines, three bytes high to low
    pixq = '{24'hA1B2C3, 24'h0F1E2D, 24'h55AA33};
    run_frame(3, 0, 0);
    // R4/R5 directed: 12 bits on 8 lines, odd count
    pixq = '{24'h000ABC, 24'h000DEF, 24'h000123};
    run_frame(0, 0, 0);
    // R10: start mid-transfer with changed settings
    pixq.delete();
    for (int i = 0; i < 6; i++) pixq.push_back(24'($urandom));
    run_frame(3, 3, 1);

    chk(cfg_err == 1'b0, "R1 no error on accepted pairs", cfg_err, 0);

    // R10: zero count start ignored
    @(negedge clk);
    cfg_depth = 2'd1; cfg_lines = 2'd3; cfg_pix_count = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s_valid = 1'b1;
    #1;
    chk(busy == 0 && s_ready == 0, "R10 zero count ignored", {busy, s_ready}, 0);
    s_valid = 1'b0;

    // R1: 16 bits on 12 lines is rejected
    @(negedge clk);
    cfg_depth = 2'd1; cfg_lines = 2'd2; cfg_pix_count = 16'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(cfg_err == 1'b1, "R1 error set", cfg_err, 1);
    chk(busy == 1'b0, "R1 rejected start", busy, 0);

    // random frames over all accepted pairs
    for (int t = 0; t < 36; t++) begin
      int ds, ls;
      do begin
        ds = int'($urandom % 4);
        ls = int'($urandom % 4);
      end while (fmt_of(ds, ls) < 0);
      pixq.delete();
      for (int i = 0; i < 1 + int'($urandom % 9); i++) pixq.push_back(24'($urandom));
      run_frame(ds, ls, 0);
    end

    chk(cfg_err == 1'b1, "R1 error sticky", cfg_err, 1);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule